// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

An 8-bit general-purpose I/O port that sits between a simple register bus and a row of external tri-state pads. Each pin has its own direction bit. A pin whose bit is set drives the latched output value with its output-enable asserted. A pin whose bit is clear leaves its pad floating and acts as an input. Software writes the output latch and the direction register through the bus. It reads back the direction register, or the live pin levels after they pass a synchronizer.

The output latch has no reset. It keeps its contents across reset, so software can load the desired levels first and only then turn pins into outputs. A standby interface carries a stop indication and a float-control bit. Stop with float-control set turns off every output-enable, whatever the direction bits hold. During stop the sampled input value is frozen, so floating pads cannot disturb the logic that reads them.

Top module: `gpio_port`

## Requirements
- R1: Register offset 0 holds the output latch and offset 1 holds the direction register. A direction bit of 1 asserts that pin's `pad_oe_o` bit, unless the port is floated (see R7).
- R2: A direction bit of 0 deasserts that pin's `pad_oe_o` bit, so the pad is high impedance.
- R3: A write to offset 0 updates the latch in the next cycle, even for pins set as inputs. `pad_out_o` always shows the latch, and the value reaches the pin when its direction bit becomes 1.
- R4: A read of offset 0 returns the synchronized pin level for every bit, whatever the direction setting.
- R5: While `rst_ni` is low, all direction bits are 0 and all `pad_oe_o` bits are 0. A read of offset 1 after reset returns 0.
- R6: Reset does not alter the output latch. Its previous contents are still on `pad_out_o` during and after reset.
- R7: While `stop_i` and `float_en_i` are both 1, every `pad_oe_o` bit is 0, whatever the direction register holds.
- R8: While `stop_i` is 1 and `float_en_i` is 0, `pad_oe_o` follows the direction register as in normal operation.
- R9: While `stop_i` is 1, reads of offset 0 return the pin value sampled before stop began. Fresh pin values are seen again once `stop_i` returns to 0.
- R10: The pad input passes two synchronizer flops and one input-hold register. A pad value held stable is returned by a read strobe at the fourth rising edge after it changed, and an earlier strobe returns the old value. `bus_rdata_o` is loaded at the edge that samples the read strobe and holds its value between reads.
- R11: A read of offset 1 returns the stored direction register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | Register offset: 0 latch/pins, 1 direction |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid the cycle after a read strobe |
| pad_in_i | input | 8 | Pin levels from the pads |
| pad_out_o | output | 8 | Output latch value to the pads |
| pad_oe_o | output | 8 | Per-pin output-enable to the pads |
| stop_i | input | 1 | Stop mode active |
| float_en_i | input | 1 | Float the pins during stop |

## Verification
The assertions assume a bus access lasts exactly one cycle and that the bus and standby inputs are driven cleanly away from the clock edge. Pad inputs may be asynchronous. The freeze and readback properties look one or two cycles back, so they rely on `stop_i` and the read strobe being held for whole cycles. The bench changes every input on the falling edge and pulses `bus_sel_i` for a single cycle per access, which keeps it within these assumptions. Before each data read it holds the pad value for three cycles, except in the directed latency test, which reads on purpose before the synchronizer has settled.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic {
    REG_DAT = 1'b0,
    REG_DIR = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[s] <= '0;
        else         st_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[s] <= '0;
        else         st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_dat_i,
  input  logic             wr_dir_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] dat_o,
  output logic [WIDTH-1:0] dir_o
);
  logic [WIDTH-1:0] dat_q, dir_q;

  // latch is deliberately not reset
  always_ff @(posedge clk_i)
    if (wr_dat_i) dat_q <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       dir_q <= '0;
    else if (wr_dir_i) dir_q <= wdata_i;

  assign dat_o = dat_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic             float_en_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] sync_i,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] in_o
);
  logic             float_all;
  logic [WIDTH-1:0] in_q;

  assign float_all = stop_i & float_en_i;
  assign oe_o      = dir_i & ~{WIDTH{float_all}};

  // input clamp: hold last sample through stop
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      in_q <= '0;
    else if (!stop_i) in_q <= sync_i;

  assign in_o = in_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic             bus_addr_i,
  input  logic [WIDTH-1:0] bus_wdata_i,
  output logic [WIDTH-1:0] bus_rdata_o,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o,
  input  logic             stop_i,
  input  logic             float_en_i
);
  import gpio_pkg::*;

  reg_sel_e         sel;
  logic             wr_dat, wr_dir, rd_en;
  logic [WIDTH-1:0] dat, dir, sync_in, pin_in, rdata_q;

  assign sel    = reg_sel_e'(bus_addr_i);
  assign wr_dat = bus_sel_i & bus_we_i & (sel == REG_DAT);
  assign wr_dir = bus_sel_i & bus_we_i & (sel == REG_DIR);
  assign rd_en  = bus_sel_i & ~bus_we_i;

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_dat_i(wr_dat), .wr_dir_i(wr_dir),
    .wdata_i(bus_wdata_i), .dat_o(dat), .dir_o(dir)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_in_i), .q_o(sync_in)
  );

  gpio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
    .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i), .float_en_i(float_en_i),
    .dir_i(dir), .sync_i(sync_in), .oe_o(pad_oe_o), .in_o(pin_in)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= (sel == REG_DIR) ? dir : pin_in;

  assign bus_rdata_o = rdata_q;
  assign pad_out_o   = dat;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_sel_i,
  input logic             bus_we_i,
  input logic             bus_addr_i,
  input logic [WIDTH-1:0] bus_wdata_i,
  input logic [WIDTH-1:0] bus_rdata_o,
  input logic [WIDTH-1:0] pad_out_o,
  input logic [WIDTH-1:0] pad_oe_o,
  input logic             stop_i,
  input logic             float_en_i
);
  logic wr_dir, wr_dat, rd_dat, rd_dir;
  assign wr_dir = bus_sel_i & bus_we_i & bus_addr_i;
  assign wr_dat = bus_sel_i & bus_we_i & ~bus_addr_i;
  assign rd_dat = bus_sel_i & ~bus_we_i & ~bus_addr_i;
  assign rd_dir = bus_sel_i & ~bus_we_i & bus_addr_i;

  AST_OE_TRACKS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dir && !wr_dat) |=> ((stop_i && float_en_i) || pad_oe_o == $past(bus_wdata_i))); // R1

  AST_FLOAT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && float_en_i) |-> (pad_oe_o == '0)); // R7

  AST_LATCH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dat |=> (pad_out_o == $past(bus_wdata_i))); // R3

  AST_INPUT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_dat && stop_i && $past(rd_dat) && $past(stop_i)) |=> $stable(bus_rdata_o)); // R9

  AST_DIR_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_dir && !$past(wr_dir)) |=> (bus_rdata_o == $past(pad_oe_o) || $past(stop_i && float_en_i))); // R11

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_sel_i || bus_we_i) |=> $stable(bus_rdata_o)); // R10

  always @(posedge clk_i)
    if (!rst_ni) AST_RESET_OE: assert (pad_oe_o == '0); // R5
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o), .stop_i(stop_i), .float_en_i(float_en_i)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  localparam int W = 8;
  localparam int NV = 6;
  // {dir, dat, pad}
  localparam logic [3*W-1:0] VEC [NV] = '{
    24'hFF_5A_00, 24'h00_C3_FF, 24'h0F_96_A5,
    24'hF0_01_3C, 24'hAA_FE_81, 24'h55_77_18
  };

  logic clk = 0, rst_ni = 0;
  logic bus_sel = 0, bus_we = 0, bus_addr = 0;
  logic [W-1:0] wdata = '0, pad_in = '0;
  logic [W-1:0] rdata, pad_out, pad_oe;
  logic stop = 0, float_en = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_sel_i(bus_sel), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .stop_i(stop), .float_en_i(float_en)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [W-1:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic a, output logic [W-1:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r, r0;
    repeat (3) @(negedge clk);
    chk("R5 oe in reset", pad_oe, '0);
    chk("R5 rdata in reset", rdata, '0);
    rst_ni = 1;
    rd(1, r); chk("R5 dir after reset", r, '0);

    // vector table: R1 R2 R3 R4 R11
    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] vd, vl, vp;
      {vd, vl, vp} = VEC[i];
      pad_in = vp;
      wr(1, vd); wr(0, vl);
      settle();
      chk("R1/R2 oe follows dir", pad_oe, vd);
      chk("R3 pad_out shows latch", pad_out, vl);
      rd(0, r); chk("R4 pin read", r, vp);
      rd(1, r); chk("R11 dir read", r, vd);
    end

    // R3: latch written while inputs, driven once output
    wr(1, 8'h00); wr(0, 8'h3C);
    chk("R3 latch on input pins", pad_out, 8'h3C);
    chk("R2 all inputs", pad_oe, 8'h00);
    wr(1, 8'h0F);
    chk("R3 oe after dir set", pad_oe, 8'h0F);
    chk("R3 latch kept", pad_out, 8'h3C);

    // R6: latch survives reset
    wr(0, 8'hA5); wr(1, 8'hFF);
    @(negedge clk); rst_ni = 0;
    @(negedge clk);
    chk("R5 oe cleared by reset", pad_oe, 8'h00);
    chk("R6 latch during reset", pad_out, 8'hA5);
    rst_ni = 1;
    rd(1, r); chk("R5 dir read after reset", r, 8'h00);
    wr(1, 8'hFF);
    chk("R6 latch after reset", pad_out, 8'hA5);
    chk("R1 oe after re-enable", pad_oe, 8'hFF);

    // R7/R8 stop floating
    @(negedge clk); stop = 1; float_en = 1;
    #1 chk("R7 forced float", pad_oe, 8'h00);
    @(negedge clk); float_en = 0;
    #1 chk("R8 stop without float", pad_oe, 8'hFF);
    @(negedge clk); stop = 0;

    // R9 input clamp
    pad_in = 8'h11; settle();
    @(negedge clk); stop = 1;
    pad_in = 8'hEE;
    repeat (5) @(negedge clk);
    rd(0, r); chk("R9 frozen during stop", r, 8'h11);
    rd(0, r); chk("R9 still frozen", r, 8'h11);
    @(negedge clk); stop = 0;
    settle();
    rd(0, r); chk("R9 live after stop", r, 8'hEE);

    // R10 latency and hold
    pad_in = 8'h55; settle(); settle();
    @(negedge clk); pad_in = 8'hAA;
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = 0;
    // strobes sampled at edges 2,3,4 after change
    @(negedge clk); chk("R10 edge2 old", rdata, 8'h55);
    @(negedge clk); chk("R10 edge3 old", rdata, 8'h55);
    @(negedge clk); bus_sel = 0; chk("R10 edge4 new", rdata, 8'hAA);
    r0 = rdata;
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    chk("R10 rdata holds", rdata, r0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule